// File: doc/BRIEF.md
# Processor Clock Source Selector and Divider

This block produces the processor clock from one of four source clocks: main, sub, ring oscillator and PLL. Every source arrives as a one-cycle tick on a single fast reference clock, and the processor clock leaves the same way, as a one-cycle enable pulse. Because both sides are enables, the model has no gated or combinational clock. Software programs a divider control made of a forced divide-by-8 bit and a two-bit ratio field. Hardware also sets the forced bit by itself when the part enters stop mode from any mode other than low-speed, and when the main oscillator is shut off while in low-speed mode.

A change of source or ratio never shortens a period. A two-state controller holds the new setting as pending, and the setting takes effect only when the running period ends. The two states are ST_STEADY, where the active setting equals the requested one, and ST_PENDING, where they differ. The controller moves from ST_STEADY to ST_PENDING when the request changes. It moves from ST_PENDING back to ST_STEADY at a period boundary, loading the request, or at once if the request returns to the active setting.

A bus clock copy of the processor clock is driven only in external-bus mode while its disable bit is low.

Top module: `cpu_clk_divider`

## Requirements
- R1: `src_sel` encodes 00 = main, 01 = sub, 10 = ring oscillator, 11 = PLL. Processor clock pulses are derived only from the ticks of the selected source.
- R2: For main or ring oscillator, `force8_q` = 1 divides by 8. Otherwise `ratio_q` 00, 01, 10 and 11 divide by 1, 2, 4 and 16. A source ticking every reference cycle then gives a `cpu_tick` pulse every N cycles.
- R3: The sub source bypasses the divider and is never divided, whatever the control bits hold.
- R4: The PLL source is always undivided. `pll_ratio_err` is 1 while PLL is selected and `force8_q` = 1 or `ratio_q` is not 00.
- R5: After reset, `force8_q` = 1 and `ratio_q` = 00, and the main source is divided by 8.
- R6: A cycle with `ctl_wr` = 1 loads `wr_force8` and `wr_ratio`, and both are visible on the read-back outputs after the next clock edge. Without `ctl_wr`, `ratio_q` holds.
- R7: A `stop_entry` pulse while `low_speed` = 0 sets `force8_q` on the next edge. While `low_speed` = 1, the pulse has no effect.
- R8: A `main_off` pulse while `low_speed` = 1 sets `force8_q` on the next edge. While `low_speed` = 0, the pulse has no effect.
- R9: When a hardware set and a write of `wr_force8` = 0 fall in the same cycle, `force8_q` ends at 1, while the ratio field still takes the written value.
- R10: A new divider setting takes effect only at the end of the period in progress. That period completes at its old length, and later periods use the new length.
- R11: `bus_oe` = `ext_bus_mode` AND NOT `bclk_dis`. `bus_tick` equals `cpu_tick` while `bus_oe` = 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_tick | input | 1 | Main source edge enable |
| sub_tick | input | 1 | Sub source edge enable |
| ring_tick | input | 1 | Ring oscillator edge enable |
| pll_tick | input | 1 | PLL edge enable |
| src_sel | input | 2 | Source select (00 main, 01 sub, 10 ring, 11 PLL) |
| ctl_wr | input | 1 | Divider control write strobe |
| wr_force8 | input | 1 | Forced divide-by-8 write value |
| wr_ratio | input | 2 | Ratio field write value |
| stop_entry | input | 1 | Stop mode entry strobe |
| main_off | input | 1 | Main oscillator shutdown strobe |
| low_speed | input | 1 | Low-speed mode flag |
| ext_bus_mode | input | 1 | External-bus mode flag |
| bclk_dis | input | 1 | Bus clock output disable |
| cpu_tick | output | 1 | Processor clock enable pulse |
| bus_tick | output | 1 | Bus clock enable pulse |
| bus_oe | output | 1 | Bus clock output enable |
| force8_q | output | 1 | Forced divide-by-8 read-back |
| ratio_q | output | 2 | Ratio field read-back |
| pll_ratio_err | output | 1 | PLL selected with a divided ratio |

## Verification
The hardest situation to reach is a ratio change that lands in the middle of a long period. Checking it needs a write at a known phase between two output pulses, and then a measurement of the period in progress and of the one after it. The bench first settles on divide-by-16 and waits for a pulse. It then writes the undivided ratio three cycles later. It expects the next gap to be a full 16 cycles and the following gap to be 1. Separate vectors drive ticks only on the selected source, so a wrong source choice shows up as missing pulses.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'b00,
        SRC_SUB  = 2'b01,
        SRC_RING = 2'b10,
        SRC_PLL  = 2'b11
    } clk_src_e;

    localparam int SHIFT_W = 3;

    typedef struct packed {
        clk_src_e             src;
        logic [SHIFT_W-1:0]   shift;
    } div_cfg_t;

    // Divide ratio as a power of two: forced bit gives 8, field gives 1/2/4/16.
    function automatic logic [SHIFT_W-1:0] ratio_shift(input logic f8, input logic [1:0] r);
        logic [SHIFT_W-1:0] s;
        if (f8) begin
            s = 3'd3;
        end else begin
            unique case (r)
                2'b00: s = 3'd0;
                2'b01: s = 3'd1;
                2'b10: s = 3'd2;
                default: s = 3'd4;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/clk_ctl_regs.sv
module clk_ctl_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       wr_force8,
    input  logic [1:0] wr_ratio,
    input  logic       stop_entry,
    input  logic       main_off,
    input  logic       low_speed,
    output logic       force8_q,
    output logic [1:0] ratio_q
);
    logic hw_set;

    assign hw_set = (stop_entry && !low_speed) || (main_off && low_speed);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force8_q <= 1'b1;
            ratio_q  <= 2'b00;
        end else begin
            if (ctl_wr) begin
                force8_q <= wr_force8;
                ratio_q  <= wr_ratio;
            end
            if (hw_set) begin
                force8_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/clk_switch_fsm.sv
module clk_switch_fsm
    import cpu_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_cfg_t req,
    input  logic     at_boundary,
    output div_cfg_t act
);
    typedef enum logic {ST_STEADY = 1'b0, ST_PENDING = 1'b1} sw_state_e;

    sw_state_e state, state_nx;
    logic      differ;

    assign differ = (req != act);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_STEADY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STEADY:  if (differ) state_nx = ST_PENDING;
            ST_PENDING: if (!differ || at_boundary) state_nx = ST_STEADY;
            default:    state_nx = ST_STEADY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act.src   <= SRC_MAIN;
            act.shift <= 3'd3;
        end else if (state == ST_PENDING && at_boundary) begin
            act <= req;
        end
    end
endmodule

// File: rtl/clk_div_counter.sv
module clk_div_counter
    import cpu_clk_pkg::*;
#(
    parameter int MAX_SHIFT = 4,
    localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] src_ticks,
    input  div_cfg_t   act,
    output logic       at_boundary,
    output logic       cpu_tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             sel_tick;
    logic             fire;

    always_comb begin
        last = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (i < int'(act.shift)) last[i] = 1'b1;
        end
    end

    assign sel_tick    = src_ticks[act.src];
    assign fire        = sel_tick && (cnt == last);
    assign at_boundary = fire || (cnt == '0 && !sel_tick);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            cpu_tick <= 1'b0;
        end else begin
            cpu_tick <= fire;
            if (sel_tick) begin
                cnt <= fire ? '0 : cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider
    import cpu_clk_pkg::*;
#(
    parameter int MAX_SHIFT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_tick,
    input  logic       sub_tick,
    input  logic       ring_tick,
    input  logic       pll_tick,
    input  logic [1:0] src_sel,
    input  logic       ctl_wr,
    input  logic       wr_force8,
    input  logic [1:0] wr_ratio,
    input  logic       stop_entry,
    input  logic       main_off,
    input  logic       low_speed,
    input  logic       ext_bus_mode,
    input  logic       bclk_dis,
    output logic       cpu_tick,
    output logic       bus_tick,
    output logic       bus_oe,
    output logic       force8_q,
    output logic [1:0] ratio_q,
    output logic       pll_ratio_err
);
    div_cfg_t   req;
    div_cfg_t   act;
    logic       at_boundary;
    logic [3:0] src_ticks;
    clk_src_e   src;

    assign src       = clk_src_e'(src_sel);
    assign src_ticks = {pll_tick, ring_tick, sub_tick, main_tick};

    clk_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_force8(wr_force8),
        .wr_ratio(wr_ratio), .stop_entry(stop_entry), .main_off(main_off),
        .low_speed(low_speed), .force8_q(force8_q), .ratio_q(ratio_q)
    );

    always_comb begin
        req.src = src;
        if (src == SRC_MAIN || src == SRC_RING) begin
            req.shift = ratio_shift(force8_q, ratio_q);
        end else begin
            req.shift = '0;
        end
    end

    assign pll_ratio_err = (src == SRC_PLL) && (force8_q || ratio_q != 2'b00);

    clk_switch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .at_boundary(at_boundary), .act(act)
    );

    clk_div_counter #(.MAX_SHIFT(MAX_SHIFT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .src_ticks(src_ticks), .act(act),
        .at_boundary(at_boundary), .cpu_tick(cpu_tick)
    );

    assign bus_oe   = ext_bus_mode && !bclk_dis;
    assign bus_tick = cpu_tick && bus_oe;
endmodule

// File: rtl/cpu_clk_divider_chk.sv
module cpu_clk_divider_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       stop_entry,
    input logic       main_off,
    input logic       low_speed,
    input logic [1:0] src_sel,
    input logic       cpu_tick,
    input logic       bus_tick,
    input logic       bus_oe,
    input logic       force8_q,
    input logic [1:0] ratio_q,
    input logic       pll_ratio_err
);
    // R11
    bus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> !bus_tick);

    // R11
    bus_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_tick |-> cpu_tick);

    // R7
    stop_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_entry && !low_speed) |=> force8_q);

    // R8
    mainoff_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_off && low_speed) |=> force8_q);

    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ratio_q));

    // R4
    pll_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b11 && (ratio_q != 2'b00 || force8_q)) |-> pll_ratio_err);
endmodule

bind cpu_clk_divider cpu_clk_divider_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .stop_entry(stop_entry),
    .main_off(main_off), .low_speed(low_speed), .src_sel(src_sel),
    .cpu_tick(cpu_tick), .bus_tick(bus_tick), .bus_oe(bus_oe),
    .force8_q(force8_q), .ratio_q(ratio_q), .pll_ratio_err(pll_ratio_err)
);

// File: tb/tb_cpu_clk_divider.sv
module tb_cpu_clk_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ticks = 4'b0001;
    logic [1:0] src_sel = 2'b00;
    logic       ctl_wr = 1'b0, wr_force8 = 1'b0;
    logic [1:0] wr_ratio = 2'b00;
    logic       stop_entry = 1'b0, main_off = 1'b0, low_speed = 1'b0;
    logic       ext_bus_mode = 1'b0, bclk_dis = 1'b0;
    logic       cpu_tick, bus_tick, bus_oe, force8_q, pll_ratio_err;
    logic [1:0] ratio_q;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cpu_clk_divider dut (
        .clk(clk), .rst_n(rst_n), .main_tick(ticks[0]), .sub_tick(ticks[1]),
        .ring_tick(ticks[2]), .pll_tick(ticks[3]), .src_sel(src_sel),
        .ctl_wr(ctl_wr), .wr_force8(wr_force8), .wr_ratio(wr_ratio),
        .stop_entry(stop_entry), .main_off(main_off), .low_speed(low_speed),
        .ext_bus_mode(ext_bus_mode), .bclk_dis(bclk_dis), .cpu_tick(cpu_tick),
        .bus_tick(bus_tick), .bus_oe(bus_oe), .force8_q(force8_q),
        .ratio_q(ratio_q), .pll_ratio_err(pll_ratio_err)
    );

    typedef struct packed {
        logic [1:0] src;
        logic       f8;
        logic [1:0] ratio;
        logic [7:0] gap;
        logic       err;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 2'b00, 8'd1,  1'b0},
        '{2'b00, 1'b0, 2'b01, 8'd2,  1'b0},
        '{2'b00, 1'b0, 2'b10, 8'd4,  1'b0},
        '{2'b00, 1'b0, 2'b11, 8'd16, 1'b0},
        '{2'b00, 1'b1, 2'b01, 8'd8,  1'b0},
        '{2'b10, 1'b0, 2'b01, 8'd2,  1'b0},
        '{2'b10, 1'b1, 2'b00, 8'd8,  1'b0},
        '{2'b01, 1'b0, 2'b11, 8'd1,  1'b0},
        '{2'b11, 1'b0, 2'b00, 8'd1,  1'b0},
        '{2'b11, 1'b0, 2'b10, 8'd1,  1'b1},
        '{2'b10, 1'b0, 2'b11, 8'd16, 1'b0}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_ctl(input logic f8, input logic [1:0] r);
        @(negedge clk);
        ctl_wr = 1'b1; wr_force8 = f8; wr_ratio = r;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic pulse_hw(input logic stp, input logic moff);
        @(negedge clk);
        stop_entry = stp; main_off = moff;
        @(negedge clk);
        stop_entry = 1'b0; main_off = 1'b0;
    endtask

    task automatic get_gap(output int g);
        int n;
        n = 0;
        @(negedge clk);
        while (cpu_tick !== 1'b1 && n < 300) begin
            @(negedge clk);
            n++;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cpu_tick !== 1'b1 && n < 300);
        g = (n >= 300) ? 0 : n;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int g;
        int c;
        int np;
        int mism;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: reset state
        check("R5", "force8 after reset", int'(force8_q), 1);
        check("R5", "ratio after reset", int'(ratio_q), 0);
        get_gap(g);
        get_gap(g);
        check("R5", "main gap after reset", g, 8);

        // Vector table: source select and ratio decode
        for (int i = 0; i < NVEC; i++) begin
            src_sel = VECS[i].src;
            ticks = 4'b0001 << VECS[i].src;
            write_ctl(VECS[i].f8, VECS[i].ratio);
            // R6: read-back
            check("R6", "force8 readback", int'(force8_q), int'(VECS[i].f8));
            check("R6", "ratio readback", int'(ratio_q), int'(VECS[i].ratio));
            get_gap(g);
            get_gap(g);
            get_gap(g);
            if (VECS[i].src == 2'b01)      tag = "R3";
            else if (VECS[i].src == 2'b11) tag = "R4";
            else                           tag = "R2";
            check(tag, "pulse gap", g, int'(VECS[i].gap));
            check(tag, "pll ratio error", int'(pll_ratio_err), int'(VECS[i].err));
        end

        // R1: ring selected, only main ticking -> no pulses
        src_sel = 2'b10;
        ticks = 4'b0001;
        write_ctl(1'b0, 2'b00);
        repeat (40) @(negedge clk);
        np = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (cpu_tick) np++;
        end
        check("R1", "pulses from unselected source", np, 0);
        ticks = 4'b0100;
        get_gap(g);
        get_gap(g);
        check("R1", "ring gap once ticking", g, 1);

        // R10: ratio change mid-period completes the old period
        src_sel = 2'b00;
        ticks = 4'b0001;
        write_ctl(1'b0, 2'b11);
        get_gap(g);
        get_gap(g);
        get_gap(g);
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (c == 3) begin
                ctl_wr = 1'b1; wr_force8 = 1'b0; wr_ratio = 2'b00;
            end else begin
                ctl_wr = 1'b0;
            end
        end while (cpu_tick !== 1'b1 && c < 300);
        ctl_wr = 1'b0;
        check("R10", "period in progress at change", c, 16);
        get_gap(g);
        check("R10", "period after change", g, 1);

        // R7: stop entry outside low-speed sets force8
        write_ctl(1'b0, 2'b01);
        low_speed = 1'b0;
        pulse_hw(1'b1, 1'b0);
        check("R7", "force8 after stop entry", int'(force8_q), 1);
        write_ctl(1'b0, 2'b01);
        low_speed = 1'b1;
        pulse_hw(1'b1, 1'b0);
        check("R7", "stop entry in low-speed ignored", int'(force8_q), 0);

        // R8: main off in low-speed sets force8
        pulse_hw(1'b0, 1'b1);
        check("R8", "force8 after main off", int'(force8_q), 1);
        write_ctl(1'b0, 2'b01);
        low_speed = 1'b0;
        pulse_hw(1'b0, 1'b1);
        check("R8", "main off outside low-speed ignored", int'(force8_q), 0);

        // R9: hardware set beats simultaneous write
        @(negedge clk);
        ctl_wr = 1'b1; wr_force8 = 1'b0; wr_ratio = 2'b10; stop_entry = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; stop_entry = 1'b0;
        check("R9", "force8 on collision", int'(force8_q), 1);
        check("R9", "ratio on collision", int'(ratio_q), 2);

        // R11: bus clock gating
        write_ctl(1'b0, 2'b01);
        ext_bus_mode = 1'b1; bclk_dis = 1'b0;
        @(negedge clk);
        check("R11", "bus_oe enabled", int'(bus_oe), 1);
        np = 0; mism = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bus_tick) np++;
            if (bus_tick != cpu_tick) mism++;
        end
        check("R11", "bus follows cpu mismatches", mism, 0);
        check("R11", "bus pulses seen", int'(np > 0), 1);
        bclk_dis = 1'b1;
        @(negedge clk);
        check("R11", "bus_oe when disabled", int'(bus_oe), 0);
        np = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bus_tick) np++;
        end
        check("R11", "bus pulses when disabled", np, 0);
        ext_bus_mode = 1'b0; bclk_dis = 1'b0;
        @(negedge clk);
        check("R11", "bus_oe outside bus mode", int'(bus_oe), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule